// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is a purely combinational integer arithmetic logic unit for two's complement operands. A 3-bit operation code picks one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Alongside the result it reports a zero flag, a signed overflow flag and the carry out of the most significant bit.

Addition and subtraction use the same ripple adder. The top opcode bit inverts the second operand and also feeds the carry-in of bit 0, so subtraction is computed as `a + ~b + 1`. Set-on-less-than reuses that subtraction and corrects the sign of the difference with the overflow flag. This means the comparison stays right even when the difference does not fit in the word.

The operand width is a parameter with a default of 32. A narrow instance behaves in exactly the same way, and the bench uses one for exhaustive coverage.

Top module: `int_alu`

## Requirements
- R1: Opcode 3'b000 drives the bitwise AND of the operands onto the result.
- R2: Opcode 3'b001 drives the bitwise OR of the operands onto the result.
- R3: Opcode 3'b010 drives `(a + b) mod 2^WIDTH` onto the result and puts the carry out of the top bit on the carry output.
- R4: Opcode 3'b110 drives `(a + ~b + 1) mod 2^WIDTH` onto the result and puts the carry out of the top bit on the carry output; this carry is 1 exactly when a is unsigned-greater-or-equal to b.
- R5: For add and subtract, the overflow flag is 1 exactly when the two adder inputs (a, and b or ~b) share a sign and the result has the other sign.
- R6: Opcode 3'b111 gives result bit 0 = 1 exactly when a < b as signed numbers, with all higher result bits 0. The overflow and carry outputs report the subtraction `a - b`.
- R7: For the five defined opcodes, the zero flag is 1 exactly when every result bit is 0.
- R8: Opcodes 3'b011, 3'b100 and 3'b101 give a zero result with the zero, overflow and carry outputs all 0.
- R9: For AND and OR, the overflow and carry outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros (defined opcodes only) |
| ovf_o | output | 1 | Signed overflow of the adder |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach is a signed comparison whose subtraction overflows. Here the sign of the raw difference points the wrong way, and only the correction term gives the right answer. Reaching it takes operands of opposite sign that lie near the ends of the range. A 4-bit instance is therefore swept over every operand pair and every opcode, which hits every such pair. A 32-bit instance gets directed extreme values and pseudo-random words, all compared against an arithmetic model in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

endpackage

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             pick_or_i,
    output logic [WIDTH-1:0] out_o
);

    // per-bit two-input gate, selected by the low opcode bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign out_o[i] = pick_or_i ? (lhs_i[i] | rhs_i[i]) : (lhs_i[i] & rhs_i[i]);
    end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             negate_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] rhs_eff;

    // negate control doubles as carry into bit 0
    assign chain[0] = negate_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign rhs_eff[i]  = rhs_i[i] ^ negate_i;
        assign sum_o[i]    = lhs_i[i] ^ rhs_eff[i] ^ chain[i];
        assign chain[i+1]  = (lhs_i[i] & rhs_eff[i]) | (chain[i] & (lhs_i[i] ^ rhs_eff[i]));
    end

    assign carry_o = chain[WIDTH];
    // signed overflow: carry into top bit differs from carry out of it
    assign ovf_o   = chain[WIDTH] ^ chain[WIDTH-1];

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] add_res;
    logic             add_carry;
    logic             add_ovf;
    logic             is_arith;
    logic             is_defined;
    logic             less_bit;

    int_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .lhs_i     (opa_i),
        .rhs_i     (opb_i),
        .pick_or_i (op_i[0]),
        .out_o     (logic_res)
    );

    int_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .lhs_i    (opa_i),
        .rhs_i    (opb_i),
        .negate_i (op_i[2]),
        .sum_o    (add_res),
        .carry_o  (add_carry),
        .ovf_o    (add_ovf)
    );

    // corrected sign of the difference
    assign less_bit = add_res[MSB] ^ add_ovf;

    always_comb begin
        res_o      = '0;
        is_arith   = 1'b0;
        is_defined = 1'b1;
        unique case (op_i)
            OP_AND, OP_OR: res_o = logic_res;
            OP_ADD, OP_SUB: begin
                res_o    = add_res;
                is_arith = 1'b1;
            end
            OP_SLT: begin
                res_o    = {{MSB{1'b0}}, less_bit};
                is_arith = 1'b1;
            end
            default: is_defined = 1'b0;
        endcase
    end

    assign zero_o = is_defined & ~(|res_o);
    assign ovf_o  = is_arith & add_ovf;
    assign cout_o = is_arith & add_carry;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] res_o,
    input logic             zero_o,
    input logic             ovf_o,
    input logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        // R8
        unused_op_chk: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
                               || (res_o == '0 && !zero_o && !ovf_o && !cout_o));
        // R9
        logic_flags_chk: assert (op_i[2:1] != 2'b00 || (!ovf_o && !cout_o));
        // R6
        slt_upper_chk: assert (op_i != 3'b111 || res_o[MSB:1] == '0);
        // R7
        zero_flag_chk: assert (!(op_i[2:1] == 2'b00 || op_i == 3'b010 || op_i[2:1] == 2'b11)
                               || (zero_o == (res_o == '0)));
        // R5
        add_overflow_chk: assert (op_i != 3'b010
                                  || ovf_o == ((opa_i[MSB] == opb_i[MSB]) && (res_o[MSB] != opa_i[MSB])));
        // R5
        sub_overflow_chk: assert (op_i != 3'b110
                                  || ovf_o == ((opa_i[MSB] != opb_i[MSB]) && (res_o[MSB] != opa_i[MSB])));
    end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .zero_o (zero_o),
    .ovf_o  (ovf_o),
    .cout_o (cout_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;

    localparam int W_WIDE = 32;
    localparam int W_NIB  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [W_WIDE-1:0] wa, wb, wres;
    logic [2:0]        wop;
    logic              wz, wv, wc;

    logic [W_NIB-1:0]  na, nb, nres;
    logic [2:0]        nop;
    logic              nz, nv, nc;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int_alu #(.WIDTH(W_WIDE)) uut (
        .opa_i(wa), .opb_i(wb), .op_i(wop),
        .res_o(wres), .zero_o(wz), .ovf_o(wv), .cout_o(wc)
    );

    int_alu #(.WIDTH(W_NIB)) uut_nib (
        .opa_i(na), .opb_i(nb), .op_i(nop),
        .res_o(nres), .zero_o(nz), .ovf_o(nv), .cout_o(nc)
    );

    function automatic void model(input int w, input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] op, output logic [31:0] r,
                                  output logic z, output logic v, output logic c);
        longint unsigned m;
        longint unsigned s;
        longint          sa;
        longint          sb;
        logic            as, bs, rs;
        m  = (64'd1 << w) - 1;
        as = a[w-1];
        bs = b[w-1];
        sa = as ? longint'(a) - longint'(64'd1 << w) : longint'(a);
        sb = bs ? longint'(b) - longint'(64'd1 << w) : longint'(b);
        r = '0; z = 1'b0; v = 1'b0; c = 1'b0;
        case (op)
            3'b000: begin r = a & b; z = (r == 0); end
            3'b001: begin r = a | b; z = (r == 0); end
            3'b010: begin
                s  = 64'(a) + 64'(b);
                r  = 32'(s & m);
                c  = s[w];
                rs = r[w-1];
                v  = (as == bs) && (rs != as);
                z  = (r == 0);
            end
            3'b110, 3'b111: begin
                s  = 64'(a) + ((~64'(b)) & m) + 64'd1;
                c  = s[w];
                rs = s[w-1];
                v  = (as != bs) && (rs != as);
                if (op == 3'b110) r = 32'(s & m);
                else              r = (sa < sb) ? 32'd1 : 32'd0;
                z  = (r == 0);
            end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3/R5";
            3'b110:  return "R4/R5";
            3'b111:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] ar, input logic [31:0] er,
                           input logic [2:0] af, input logic [2:0] ef);
        checks++;
        if (ar !== er || af !== ef) begin
            errors++;
            $display("FAIL %s: res=%h zvc=%b expected res=%h zvc=%b", tag, ar, af, er, ef);
        end
    endtask

    task automatic run_wide(input string tag, input logic [31:0] a, input logic [31:0] b,
                            input logic [2:0] op);
        logic [31:0] er;
        logic ez, ev, ec;
        @(negedge clk);
        wa = a; wb = b; wop = op;
        #2;
        model(W_WIDE, a, b, op, er, ez, ev, ec);
        compare(tag, wres, er, {wz, wv, wc}, {ez, ev, ec});
    endtask

    initial begin
        wa = '0; wb = '0; wop = 3'b000;
        na = '0; nb = '0; nop = 3'b000;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7 idle: AND of zeros gives zero flag
        @(negedge clk); #2;
        compare("R7 idle", wres, 32'd0, {wz, wv, wc}, 3'b100);

        // exhaustive 4-bit sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [31:0] er;
                    logic ez, ev, ec;
                    @(negedge clk);
                    na = 4'(a); nb = 4'(b); nop = 3'(op);
                    #2;
                    model(W_NIB, 32'(a), 32'(b), 3'(op), er, ez, ev, ec);
                    compare({"nib ", tag_of(3'(op))}, 32'(nres), er, {nz, nv, nc}, {ez, ev, ec});
                end
            end
        end

        // directed 32-bit corners
        run_wide("R5 add max+1",        32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
        run_wide("R3 add carry wrap",   32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
        run_wide("R5 sub min-1",        32'h8000_0000, 32'h0000_0001, 3'b110);
        run_wide("R4 sub equal",        32'h1234_5678, 32'h1234_5678, 3'b110);
        run_wide("R4 sub borrow",       32'h0000_0001, 32'h0000_0002, 3'b110);
        run_wide("R6 slt -1<1",         32'hFFFF_FFFF, 32'h0000_0001, 3'b111);
        run_wide("R6 slt min<max",      32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
        run_wide("R6 slt max<min",      32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
        run_wide("R1 and mask",         32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
        run_wide("R2 or",               32'hF000_0001, 32'h0000_1000, 3'b001);
        run_wide("R9 and flags",        32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000);
        run_wide("R8 op011",            32'hFFFF_FFFF, 32'h0000_0001, 3'b011);
        run_wide("R8 op100",            32'h8000_0000, 32'h8000_0000, 3'b100);
        run_wide("R8 op101",            32'h0000_0000, 32'h0000_0000, 3'b101);

        // pseudo-random 32-bit words over every opcode
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (k % 5 == 0) ? ra : 32'($urandom);
            run_wide({"rand ", tag_of(3'(k % 8))}, ra, rb, 3'(k % 8));
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule